// File: doc/BRIEF.md
# Host Receive Status and Data Queue

This block sits on the host side of a packet receive path. The packet engine pushes two kinds of 32-bit entries into one shared queue: status words that describe a received packet or a transfer-completion event, and the data words of a packet. Software reads the queue through two pop ports. The status port shows the head entry when it is a status word. The data port shows the head entry when it is a data word. A level interrupt tells software that a status word is waiting at the head.

An entry becomes visible to the readers only after the engine closes the packet with the `push_last` flag. A half-written packet therefore never raises the interrupt. The engine writes a completion status word after the data packet. When software pops that completion word, a sticky per-channel transfer-done flag is set. A per-channel packet counter, loaded by software, counts down on every data-packet status word the engine writes. Once the completion is seen, software reads the counter to tell a full transfer (zero) from an early stop (non-zero).

Status word layout: channel in bits [3:0], byte count in bits [14:4], status code in bits [18:15]. Bits [31:19] are zero. Code 4'b0010 marks a data packet and code 4'b0011 marks a transfer completion. Every other code is a non-data status entry with no side effect.

Top module: `rx_status_fifo`

## Requirements
- R1: Entries leave the queue in the order they were written. While the head visible entry is a status word, `stat_valid` is 1 and `stat_word` carries it, with the channel in [3:0], the byte count in [14:4] and the code in [18:15]. Otherwise `stat_valid` is 0 and `stat_word` is zero. `stat_pop` removes only a status head.
- R2: Written entries stay invisible to both read ports until a push with `push_last`=1 is accepted. That push makes every entry written so far visible in the next cycle.
- R3: The receive-level pending state is 1 exactly when the head visible entry is a status word. `rxlvl_irq` equals that pending state while `rxlvl_mask` is 0.
- R4: `rxlvl_mask`=1 forces `rxlvl_irq` to 0 but changes no queue state. Clearing the mask with a status word still at the head makes `rxlvl_irq` 1 again at once.
- R5: While the head visible entry is a data word, `data_valid` is 1 and `data_word` carries it. `data_pop` removes it. Otherwise `data_word` is zero.
- R6: A `data_pop` while the head visible entry is not a data word removes nothing and sets `rd_err` from the next cycle. `rd_err` stays set until `err_clr`. A new error in the same cycle as `err_clr` wins.
- R7: Popping a status word with code 4'b0011 sets `xfer_done[channel]` from the next cycle. The bit stays set until the matching bit of `done_clr` is 1. A set in the same cycle wins over the clear. Popping a status word with any other code sets no done bit.
- R8: An accepted status push with code 4'b0010 decrements the packet counter of its channel by one. The counter saturates at zero. No other push changes any counter.
- R9: `pkt_load` writes `pkt_load_val` into the counter of `pkt_load_chan`. It wins over a decrement of the same channel in the same cycle. `pkt_cnt` shows the counter of `pkt_sel`.
- R10: The queue holds `DEPTH` entries (default 512, at least 258 = one 1024-byte packet plus two status words). `fifo_full` is 1 when `DEPTH` entries are stored. A push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Engine writes one entry |
| push_is_stat | input | 1 | Entry is a status word (1) or a data word (0) |
| push_last | input | 1 | Closes the packet and makes all entries written so far visible |
| push_word | input | 32 | Entry contents |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| stat_valid | output | 1 | Head visible entry is a status word |
| stat_word | output | 32 | Head status word, zero when none |
| stat_pop | input | 1 | Pop the head status word |
| data_valid | output | 1 | Head visible entry is a data word |
| data_word | output | 32 | Head data word, zero when none |
| data_pop | input | 1 | Pop the head data word |
| rd_err | output | 1 | Sticky flag for a data pop with no data at the head |
| err_clr | input | 1 | Clears rd_err |
| rxlvl_mask | input | 1 | Masks the receive-level interrupt output |
| rxlvl_irq | output | 1 | Receive-level interrupt |
| xfer_done | output | 16 | Sticky transfer-complete flag per channel |
| done_clr | input | 16 | Clears the matching xfer_done bits |
| pkt_load | input | 1 | Load a packet counter |
| pkt_load_chan | input | 4 | Channel to load |
| pkt_load_val | input | 10 | Value to load |
| pkt_sel | input | 4 | Channel whose counter is shown |
| pkt_cnt | output | 10 | Packet counter of pkt_sel |

## Verification
A wrong commit pointer shows up at the ports in the very cycle after the closing push. Either a status word appears on `stat_valid` before its packet is complete, or a closed packet stays hidden. A bad read pointer or a bad head tag shows up at once as a wrong word or a wrong valid on one of the two read ports. A bad counter or a bad flag register shows up one cycle after the push or pop that touched it, on `pkt_cnt`, `xfer_done` or `rd_err`. The bench runs a behavioural queue model next to the design and compares every output on every cycle, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/rxsf_pkg.sv
// Package rxsf_pkg
// Shared constants and field helpers for the receive status queue.
// Assumes the status word layout given in the brief: channel [3:0],
// byte count [14:4] and code [18:15].
package rxsf_pkg;
    localparam int WORD_W  = 32;
    localparam int CHAN_W  = 4;
    localparam int BCNT_W  = 11;
    localparam int CODE_W  = 4;
    localparam logic [CODE_W-1:0] CODE_DATA = 4'b0010;
    localparam logic [CODE_W-1:0] CODE_CMPL = 4'b0011;

    // One stored queue entry: the kind tag plus the 32-bit payload.
    typedef struct packed {
        logic              is_stat;
        logic [WORD_W-1:0] word;
    } entry_t;

    function automatic logic [CHAN_W-1:0] f_chan(input logic [WORD_W-1:0] w);
        return w[CHAN_W-1:0];
    endfunction

    function automatic logic [CODE_W-1:0] f_code(input logic [WORD_W-1:0] w);
        return w[CHAN_W+BCNT_W +: CODE_W];
    endfunction
endpackage

// File: rtl/rxsf_store.sv
// Module rxsf_store
// Entry memory with write, commit and read pointers. Entries up to the
// commit pointer are visible at the head. Assumes DEPTH is a power of two
// and that pop is issued only when head_ok is 1.
module rxsf_store
    import rxsf_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              push_is_stat,
    input  logic              push_last,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic              full,
    output logic              head_ok,
    output logic              head_is_stat,
    output logic [WORD_W-1:0] head_word
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    entry_t          mem [DEPTH];
    logic   [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
    logic            acc;

    assign full    = (wr_ptr - rd_ptr) == PW'(DEPTH);
    assign acc     = push && !full;
    assign head_ok = cm_ptr != rd_ptr;

    // Payload storage, no reset needed.
    always_ff @(posedge clk) begin
        if (acc) mem[wr_ptr[AW-1:0]] <= '{is_stat: push_is_stat, word: push_word};
    end

    // Pointer update: write, commit on the closing push, read on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (acc)              wr_ptr <= wr_ptr + 1'b1;
            if (acc && push_last) cm_ptr <= wr_ptr + 1'b1;
            if (pop)              rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Head view.
    always_comb begin
        head_is_stat = mem[rd_ptr[AW-1:0]].is_stat;
        head_word    = mem[rd_ptr[AW-1:0]].word;
    end
endmodule

// File: rtl/rxsf_pktcnt.sv
// Module rxsf_pktcnt
// Per-channel packet counters: a load has priority over a decrement, and a
// decrement stops at zero. Assumes NCH <= 2**CHAN_W.
module rxsf_pktcnt
    import rxsf_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic [CHAN_W-1:0] dec_chan,
    input  logic              load,
    input  logic [CHAN_W-1:0] load_chan,
    input  logic [CW-1:0]     load_val,
    input  logic [CHAN_W-1:0] sel,
    output logic [CW-1:0]     cnt_out
);
    logic [CW-1:0] cnt [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Counter of channel c.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[c] <= '0;
            else if (load && load_chan == CHAN_W'(c))
                cnt[c] <= load_val;
            else if (dec_en && dec_chan == CHAN_W'(c) && cnt[c] != '0)
                cnt[c] <= cnt[c] - 1'b1;
        end
    end

    // Read mux for the selected channel.
    always_comb begin
        cnt_out = '0;
        for (int c = 0; c < NCH; c++)
            if (sel == CHAN_W'(c)) cnt_out = cnt[c];
    end
endmodule

// File: rtl/rxsf_flags.sv
// Module rxsf_flags
// Sticky transfer-done bits, the sticky read error and the masked level
// interrupt. A set wins over a clear in the same cycle.
module rxsf_flags
    import rxsf_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_set,
    input  logic [CHAN_W-1:0] done_chan,
    input  logic [NCH-1:0]    done_clr,
    input  logic              err_set,
    input  logic              err_clr,
    input  logic              pend,
    input  logic              mask,
    output logic [NCH-1:0]    done,
    output logic              err,
    output logic              irq
);
    logic [NCH-1:0] set_vec;

    // Decode of the channel whose completion was popped.
    always_comb begin
        set_vec = '0;
        for (int c = 0; c < NCH; c++)
            if (done_set && done_chan == CHAN_W'(c)) set_vec[c] = 1'b1;
    end

    // Sticky flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= '0;
            err  <= 1'b0;
        end else begin
            done <= (done & ~done_clr) | set_vec;
            err  <= err_set || (err && !err_clr);
        end
    end

    assign irq = pend && !mask;
endmodule

// File: rtl/rx_status_fifo.sv
// Module rx_status_fifo
// Top of the receive status queue. It joins the entry store, the packet
// counters and the flags. Assumes the engine closes every packet with
// push_last and that software uses the pop ports one entry at a time.
module rx_status_fifo
    import rxsf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int NCH   = 16,
    parameter int CW    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic              push_is_stat,
    input  logic              push_last,
    input  logic [WORD_W-1:0] push_word,
    output logic              fifo_full,
    output logic              stat_valid,
    output logic [WORD_W-1:0] stat_word,
    input  logic              stat_pop,
    output logic              data_valid,
    output logic [WORD_W-1:0] data_word,
    input  logic              data_pop,
    output logic              rd_err,
    input  logic              err_clr,
    input  logic              rxlvl_mask,
    output logic              rxlvl_irq,
    output logic [NCH-1:0]    xfer_done,
    input  logic [NCH-1:0]    done_clr,
    input  logic              pkt_load,
    input  logic [CHAN_W-1:0] pkt_load_chan,
    input  logic [CW-1:0]     pkt_load_val,
    input  logic [CHAN_W-1:0] pkt_sel,
    output logic [CW-1:0]     pkt_cnt
);
    logic              head_ok, head_is_stat, s_pop, d_pop, push_acc;
    logic [WORD_W-1:0] head_word;

    // Head classification and pop qualification.
    always_comb begin
        stat_valid = head_ok && head_is_stat;
        data_valid = head_ok && !head_is_stat;
        stat_word  = stat_valid ? head_word : '0;
        data_word  = data_valid ? head_word : '0;
        s_pop      = stat_pop && stat_valid;
        d_pop      = data_pop && data_valid;
        push_acc   = push_valid && !fifo_full;
    end

    rxsf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push_valid), .push_is_stat(push_is_stat),
        .push_last(push_last), .push_word(push_word),
        .pop(s_pop || d_pop), .full(fifo_full),
        .head_ok(head_ok), .head_is_stat(head_is_stat), .head_word(head_word)
    );

    rxsf_pktcnt #(.NCH(NCH), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .dec_en(push_acc && push_is_stat && f_code(push_word) == CODE_DATA),
        .dec_chan(f_chan(push_word)),
        .load(pkt_load), .load_chan(pkt_load_chan), .load_val(pkt_load_val),
        .sel(pkt_sel), .cnt_out(pkt_cnt)
    );

    rxsf_flags #(.NCH(NCH)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .done_set(s_pop && f_code(head_word) == CODE_CMPL),
        .done_chan(f_chan(head_word)), .done_clr(done_clr),
        .err_set(data_pop && !data_valid), .err_clr(err_clr),
        .pend(stat_valid), .mask(rxlvl_mask),
        .done(xfer_done), .err(rd_err), .irq(rxlvl_irq)
    );
endmodule

// File: rtl/rxsf_chk.sv
// Module rxsf_chk
// Port-level properties of rx_status_fifo, attached with bind below.
module rxsf_chk #(
    parameter int NCH = 16,
    parameter int CW  = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           stat_valid,
    input logic [31:0]    stat_word,
    input logic           stat_pop,
    input logic           data_valid,
    input logic           data_pop,
    input logic           rd_err,
    input logic           rxlvl_irq,
    input logic           push_valid,
    input logic [NCH-1:0] xfer_done,
    input logic           pkt_load,
    input logic [3:0]     pkt_sel,
    input logic [CW-1:0]  pkt_cnt
);
    // R7
    cmpl_pop_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_pop && stat_valid && stat_word[18:15] == 4'b0011)
        |=> xfer_done[$past(stat_word[3:0])]);

    // R6
    bad_data_pop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_pop && !data_valid) |=> rd_err);

    // R1
    head_kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_valid && data_valid));

    // R3
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxlvl_irq |-> stat_valid);

    // R8
    cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pkt_sel) && !$past(pkt_load) && !$past(push_valid))
        |-> $stable(pkt_cnt));
endmodule

bind rx_status_fifo rxsf_chk #(.NCH(NCH), .CW(CW)) u_rxsf_chk (
    .clk(clk), .rst_n(rst_n), .stat_valid(stat_valid), .stat_word(stat_word),
    .stat_pop(stat_pop), .data_valid(data_valid), .data_pop(data_pop),
    .rd_err(rd_err), .rxlvl_irq(rxlvl_irq), .push_valid(push_valid),
    .xfer_done(xfer_done), .pkt_load(pkt_load), .pkt_sel(pkt_sel),
    .pkt_cnt(pkt_cnt)
);

// File: tb/rx_status_fifo_bench.sv
`timescale 1ns/100ps
module rx_status_fifo_bench;
    localparam int DEPTH = 512;
    localparam int NCH   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 0, push_is_stat = 0, push_last = 0;
    logic [31:0] push_word = '0;
    logic        stat_pop = 0, data_pop = 0, err_clr = 0, rxlvl_mask = 0;
    logic [15:0] done_clr = '0;
    logic        pkt_load = 0;
    logic [3:0]  pkt_load_chan = '0, pkt_sel = '0;
    logic [9:0]  pkt_load_val = '0;
    logic        fifo_full, stat_valid, data_valid, rd_err, rxlvl_irq;
    logic [31:0] stat_word, data_word;
    logic [15:0] xfer_done;
    logic [9:0]  pkt_cnt;

    rx_status_fifo u_rx_status_fifo (.*);

    always #2.5 clk = ~clk;

    // Reference model state.
    logic [32:0] q[$];
    int          vis;
    int          m_cnt [NCH];
    logic [15:0] m_done;
    logic        m_err;
    int          checks = 0, errors = 0, cycles = 0;
    bit          cmp_on = 0;

    function automatic logic [31:0] mk(input int ch, input int bc, input logic [3:0] code);
        return {13'b0, code, 11'(bc), 4'(ch)};
    endfunction

    // Model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); vis = 0; m_done = '0; m_err = 0;
            foreach (m_cnt[i]) m_cnt[i] = 0;
        end else begin
            bit hs, hd, full, acc;
            logic [31:0] hw;
            logic [15:0] setv;
            hs = vis > 0 && q[0][32];
            hd = vis > 0 && !q[0][32];
            hw = (vis > 0) ? q[0][31:0] : 32'h0;
            full = q.size() == DEPTH;
            acc = push_valid && !full;
            setv = '0;
            if (stat_pop && hs) begin
                if (hw[18:15] == 4'b0011) setv[hw[3:0]] = 1'b1;
                void'(q.pop_front()); vis--;
            end else if (data_pop && hd) begin
                void'(q.pop_front()); vis--;
            end
            m_err = (data_pop && !hd) || (m_err && !err_clr);
            m_done = (m_done & ~done_clr) | setv;
            if (acc) begin
                q.push_back({push_is_stat, push_word});
                if (push_last) vis = q.size();
            end
            if (pkt_load) m_cnt[pkt_load_chan] = pkt_load_val;
            if (acc && push_is_stat && push_word[18:15] == 4'b0010
                && !(pkt_load && pkt_load_chan == push_word[3:0])
                && m_cnt[push_word[3:0]] > 0)
                m_cnt[push_word[3:0]]--;
        end
    end

    task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, nm, act, exp, $time);
        end
    endtask

    // Compare every output against the model at the falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            bit hs, hd;
            hs = vis > 0 && q[0][32];
            hd = vis > 0 && !q[0][32];
            chk("R1", "stat_valid", 32'(stat_valid), 32'(hs));
            chk("R1", "stat_word", stat_word, hs ? q[0][31:0] : 32'h0);
            chk("R5", "data_valid", 32'(data_valid), 32'(hd));
            chk("R5", "data_word", data_word, hd ? q[0][31:0] : 32'h0);
            chk("R3", "rxlvl_irq", 32'(rxlvl_irq), 32'(hs && !rxlvl_mask));
            chk("R6", "rd_err", 32'(rd_err), 32'(m_err));
            chk("R7", "xfer_done", 32'(xfer_done), 32'(m_done));
            chk("R9", "pkt_cnt", 32'(pkt_cnt), 32'(m_cnt[pkt_sel]));
            chk("R10", "fifo_full", 32'(fifo_full), 32'(q.size() == DEPTH));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic push(input bit st, input bit last, input logic [31:0] w);
        push_valid = 1; push_is_stat = st; push_last = last; push_word = w;
        tick();
        push_valid = 0; push_is_stat = 0; push_last = 0; push_word = '0;
    endtask

    initial begin
        repeat (2) tick();
        cmp_on = 1;                       // reset state checked here
        tick();
        rst_n = 1;
        tick();
        // R2: packet is hidden until closed
        push(1, 0, mk(2, 8, 4'b0010));
        push(0, 0, 32'hA5A5_0001);
        tick();
        push(0, 1, 32'hA5A5_0002);
        // R4: mask gates only the output
        rxlvl_mask = 1; tick(); tick(); rxlvl_mask = 0; tick();
        // R6: data pop with a status head
        data_pop = 1; tick(); data_pop = 0; tick();
        err_clr = 1; tick(); err_clr = 0;
        // R1 R5: pop status then data
        stat_pop = 1; tick(); stat_pop = 0;
        data_pop = 1; tick(); tick();
        // R6: empty pop, set wins over clear
        err_clr = 1; tick(); data_pop = 0; tick(); err_clr = 0;
        // R7: completion entry, then a non-data status with another code
        push(1, 1, mk(2, 0, 4'b0011));
        push(1, 1, mk(6, 0, 4'b0111));
        stat_pop = 1; tick(); tick(); stat_pop = 0; tick();
        done_clr = 16'h0004; tick(); done_clr = '0;
        // R7: set and clear in the same cycle
        push(1, 1, mk(9, 0, 4'b0011));
        stat_pop = 1; done_clr = 16'h0200; tick(); stat_pop = 0; done_clr = '0; tick();
        // R8 R9: counter load, decrement, saturation, load priority
        pkt_sel = 5; pkt_load = 1; pkt_load_chan = 5; pkt_load_val = 2; tick(); pkt_load = 0;
        for (int i = 0; i < 3; i++) push(1, 1, mk(5, 4, 4'b0010));
        push(1, 1, mk(5, 4, 4'b0011));
        pkt_load = 1; pkt_load_val = 7;
        push(1, 1, mk(5, 4, 4'b0010));
        pkt_load = 0;
        push(1, 1, mk(3, 4, 4'b0010));
        pkt_sel = 3; tick();
        for (int i = 0; i < 6; i++) begin stat_pop = 1; tick(); end
        stat_pop = 0; tick();
        // R10: fill past capacity, then push and pop together
        for (int i = 0; i < DEPTH + 4; i++) push(0, 1, 32'h1000_0000 + 32'(i));
        tick();
        data_pop = 1; push_valid = 1; push_last = 1; push_word = 32'hBEEF_0000;
        tick(); tick();
        push_valid = 0; push_last = 0;
        for (int i = 0; i < DEPTH + 2; i++) tick();
        data_pop = 0; tick(); tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule